// File: doc/BRIEF.md
# Fault and Warning Manager

This block sits between the error detectors of a three-phase gate-driver controller and the pins and registers that report those errors. It sorts each incoming error line into one of four classes. Shutdown faults are latched, pull the active-low fault pin low and force the gate outputs to high impedance. Supply faults (watchdog expiry and regulator undervoltage) are latched the same way but are reported on the power-good pin instead of the fault pin. Warnings are live and never latch. Temperature flags are live status bits that touch nothing else.

A latched error is released by a clear event, but only for the sources whose condition has gone away. There are two kinds of clear event. Software can write the clear-faults bit in the control register, and that bit drops back to zero by itself. Hardware can pulse the gate-enable input low and then high again. A latched fault always wins over a warning: while any fault is latched, the warning indication is held off.

Top module: `fault_warn_mgr`

## Requirements
- R1: A shutdown-fault condition present at a clock edge drives `fault_n` low after that edge. It also sets status bit 0 (the fault summary) and that source's bit in the latched-fault field, which starts at status bit 2 (source i at bit 2+i).
- R2: A latched fault or supply-fault bit stays set after its condition goes away, for as long as no clear event occurs.
- R3: A clear event at an edge releases each latched bit whose condition is absent at that edge. A bit whose condition is still present stays latched, so for that source the clear has no effect.
- R4: A write with `wr_en`=1, `wr_addr`=9 and `wr_data` bit 1 set makes `clr_bit` read 1 for the next cycle only. That cycle's edge is the clear event, and `clr_bit` then returns to 0 by itself. A write to another address, or with bit 1 clear, leaves `clr_bit` at 0 and clears nothing.
- R5: When `en_gate` is sampled low at one edge and high at the next, the later edge is a clear event. Holding `en_gate` steadily high or steadily low clears nothing.
- R6: `gate_hiz` is 1 whenever any shutdown fault or supply fault is latched, and it falls only when every latched bit has been released.
- R7: `warn_ind` is 1 one cycle after any warning condition is present, provided no fault of either class is latched. A latched fault forces it to 0. Warnings never move `fault_n` or `gate_hiz`.
- R8: Warnings do not latch. Status bit 1 (the warning summary) and the warning field follow the warning inputs with one cycle of delay. The warning field is placed after the latched-fault and supply-fault fields.
- R9: Temperature flags appear in the top status field with one cycle of delay and never latch. They have no effect on `fault_n`, `pwr_good`, `warn_ind` or `gate_hiz`.
- R10: A supply-fault condition latches its bit in the field that follows the latched-fault field. It drives `pwr_good` low, and leaves `fault_n` and status bit 0 unchanged.
- R11: After reset, `fault_n`=1, `pwr_good`=1, `gate_hiz`=0, `warn_ind`=0, `clr_bit`=0 and the status word is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_cond | input | N_FLT | Shutdown-fault condition lines |
| pgf_cond | input | N_PGF | Supply-fault condition lines (watchdog, undervoltage) |
| warn_cond | input | N_WARN | Warning condition lines |
| temp_cond | input | N_TEMP | Temperature flag lines |
| en_gate | input | 1 | Gate enable; a low-then-high pulse clears faults |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data; bit 1 is clear-faults |
| fault_n | output | 1 | Active-low fault pin (1 = released) |
| pwr_good | output | 1 | Power-good pin, low while a supply fault is latched |
| warn_ind | output | 1 | Warning indication |
| gate_hiz | output | 1 | Forces all gate outputs to high impedance |
| clr_bit | output | 1 | Read-back of the self-clearing clear-faults bit |
| status_word | output | 2+N_FLT+N_PGF+N_WARN+N_TEMP | Status: fault summary, warning summary, latched faults, supply faults, warnings, temperature flags |

## Verification
The bench aims at a clear request made while the condition is still asserted. A design that cleared without checking would release `fault_n` and let the gates drive into a live fault. It checks that a fault arriving during a warning suppresses `warn_ind`; a design without precedence would report both at once. It holds `en_gate` low for long stretches and repeats clear writes, which catches a level-sensitive enable clear or a clear bit that sticks at 1. Supply faults and temperature flags are mixed in randomly, so any path that leaks them onto `fault_n`, the fault summary or `gate_hiz` is caught.

// File: rtl/fwm_pkg.sv
// Shared constants, types and the latch update rule for the fault and
// warning manager. Assumes all status fields are packed LSB-first.
package fwm_pkg;

    // Bit of the control-register write data that requests a fault clear.
    localparam int CLR_BIT_POS = 1;

    // Fixed summary positions at the bottom of the status word.
    localparam int STAT_FAULT_POS  = 0;
    localparam int STAT_WARN_POS   = 1;
    localparam int STAT_FIELD_BASE = 2;

    // Origin of a clear event in the current cycle.
    typedef enum logic [1:0] {
        CLR_IDLE    = 2'b00,
        CLR_BY_REG  = 2'b01,
        CLR_BY_EN   = 2'b10,
        CLR_BY_BOTH = 2'b11
    } clr_cause_t;

    // Next value of one latched bit: a live condition always wins, otherwise
    // the held value survives unless a clear event arrives.
    function automatic logic latch_next(logic held, logic cond, logic clr);
        return cond | (held & ~clr);
    endfunction

endpackage

// File: rtl/fwm_latch_bank.sv
// Bank of sticky error bits, one per source.
// Each bit sets on its condition and releases only on a clear event while
// its own condition is absent. Assumes conditions are already synchronous.
module fwm_latch_bank #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cond,
    input  logic         clr_evt,
    output logic [N-1:0] lat
);
    import fwm_pkg::*;

    for (genvar i = 0; i < N; i++) begin : g_bit
        // Per-source sticky flop with conditional release.
        always_ff @(posedge clk) begin
            if (!rst_n) lat[i] <= 1'b0;
            else        lat[i] <= latch_next(lat[i], cond[i], clr_evt);
        end

        assert_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
            cond[i] |=> lat[i]);
        assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (lat[i] && !clr_evt) |=> lat[i]);
        assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_evt && !cond[i]) |=> !lat[i]);
    end

endmodule

// File: rtl/fwm_live_mirror.sv
// Registered, non-latching copy of live condition lines (warnings and
// temperature flags). Assumes inputs are synchronous to clk.
module fwm_live_mirror #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    // One-cycle sample of the live lines.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q == $past(d)));

endmodule

// File: rtl/fwm_clear_ctrl.sv
// Clear-event source: decodes the self-clearing clear-faults bit from the
// register write port and detects a low-then-high pulse on gate enable.
// Assumes en_gate is already synchronous to clk.
module fwm_clear_ctrl #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 9
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                en_gate,
    output logic                clr_bit,
    output fwm_pkg::clr_cause_t cause,
    output logic                clr_evt
);
    import fwm_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic wr_hit;
    logic clr_q;
    logic en_q;
    logic en_rise;
    logic unused_data;

    // Write decode of the clear-faults bit.
    assign wr_hit = wr_en && (wr_addr == CTRL_A) && wr_data[CLR_BIT_POS];
    assign unused_data = ^wr_data;

    // Clear bit: set by a write, dropped on the next edge, where it is consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= wr_hit;
    end

    // Previous enable sample; reset high so leaving reset is not a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) en_q <= 1'b1;
        else        en_q <= en_gate;
    end

    // Combine the two request sources.
    assign en_rise = en_gate & ~en_q;
    always_comb begin
        cause = clr_cause_t'({en_rise, clr_q});
    end
    assign clr_evt = (cause != CLR_IDLE);
    assign clr_bit = clr_q;

    assert_selfclear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_q && !wr_hit) |=> !clr_q);
    assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> clr_q);
    assert_enpulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |-> !$past(en_gate));

endmodule

// File: rtl/fault_warn_mgr.sv
// Fault and warning manager top. Latches shutdown faults onto the active-low
// fault pin and supply faults onto power-good. It mirrors warnings and
// temperature flags live, forces the gates to high impedance on any latched
// fault, and gives faults precedence over the warning indication.
// Assumes every input line is synchronous to clk.
module fault_warn_mgr #(
    parameter int N_FLT     = 6,
    parameter int N_PGF     = 2,
    parameter int N_WARN    = 4,
    parameter int N_TEMP    = 3,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 8,
    parameter int CTRL_ADDR = 9
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic [N_FLT-1:0]                        fault_cond,
    input  logic [N_PGF-1:0]                        pgf_cond,
    input  logic [N_WARN-1:0]                       warn_cond,
    input  logic [N_TEMP-1:0]                       temp_cond,
    input  logic                                    en_gate,
    input  logic                                    wr_en,
    input  logic [ADDR_W-1:0]                       wr_addr,
    input  logic [DATA_W-1:0]                       wr_data,
    output logic                                    fault_n,
    output logic                                    pwr_good,
    output logic                                    warn_ind,
    output logic                                    gate_hiz,
    output logic                                    clr_bit,
    output logic [2+N_FLT+N_PGF+N_WARN+N_TEMP-1:0]  status_word
);
    import fwm_pkg::*;

    localparam int SW = STAT_FIELD_BASE + N_FLT + N_PGF + N_WARN + N_TEMP;

    logic [N_FLT-1:0]  flt_lat;
    logic [N_PGF-1:0]  pgf_lat;
    logic [N_WARN-1:0] warn_q;
    logic [N_TEMP-1:0] temp_q;
    clr_cause_t        cause;
    logic              clr_evt;
    logic              any_flt;
    logic              any_pgf;

    // Clear-event generation from register write and enable pulse.
    fwm_clear_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)
    ) u_clear (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .en_gate(en_gate), .clr_bit(clr_bit),
        .cause(cause), .clr_evt(clr_evt)
    );

    // Shutdown faults, reported on the fault pin.
    fwm_latch_bank #(.N(N_FLT)) u_flt (
        .clk(clk), .rst_n(rst_n), .cond(fault_cond), .clr_evt(clr_evt), .lat(flt_lat)
    );

    // Supply faults, reported on power-good.
    fwm_latch_bank #(.N(N_PGF)) u_pgf (
        .clk(clk), .rst_n(rst_n), .cond(pgf_cond), .clr_evt(clr_evt), .lat(pgf_lat)
    );

    // Live warnings.
    fwm_live_mirror #(.N(N_WARN)) u_warn (
        .clk(clk), .rst_n(rst_n), .d(warn_cond), .q(warn_q)
    );

    // Live temperature flags.
    fwm_live_mirror #(.N(N_TEMP)) u_temp (
        .clk(clk), .rst_n(rst_n), .d(temp_cond), .q(temp_q)
    );

    // Pin and shutdown decode with fault precedence over warnings.
    always_comb begin
        any_flt  = |flt_lat;
        any_pgf  = |pgf_lat;
        fault_n  = ~any_flt;
        pwr_good = ~any_pgf;
        gate_hiz = any_flt | any_pgf;
        warn_ind = (|warn_q) & ~gate_hiz;
    end

    // Status word packing, summaries at the bottom.
    always_comb begin
        status_word = '0;
        status_word[STAT_FAULT_POS] = any_flt;
        status_word[STAT_WARN_POS]  = |warn_q;
        status_word[SW-1:STAT_FIELD_BASE] = {temp_q, warn_q, pgf_lat, flt_lat};
    end

    assert_pinquiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_cond == '0) && fault_n) |=> fault_n);
    assert_precedence_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_cond != '0) || (pgf_cond != '0)) |=> !warn_ind);
    assert_hiz_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hiz && !clr_evt) |=> gate_hiz);
    assert_temp_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!gate_hiz && (fault_cond == '0) && (pgf_cond == '0)) |=> !gate_hiz);

endmodule

// File: tb/fault_warn_mgr_test.sv
module fault_warn_mgr_test;
    localparam int NF = 6, NP = 2, NW = 4, NT = 3, AW = 4, DW = 8, CTRL = 9;
    localparam int SW = 2 + NF + NP + NW + NT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NF-1:0] fc = '0;
    logic [NP-1:0] pc = '0;
    logic [NW-1:0] wc = '0;
    logic [NT-1:0] tc = '0;
    logic en = 1'b1, wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic fault_n, pwr_good, warn_ind, gate_hiz, clr_bit;
    logic [SW-1:0] status_word;

    always #4 clk = ~clk;

    fault_warn_mgr #(.N_FLT(NF), .N_PGF(NP), .N_WARN(NW), .N_TEMP(NT),
                     .ADDR_W(AW), .DATA_W(DW), .CTRL_ADDR(CTRL)) uut (
        .clk(clk), .rst_n(rst_n), .fault_cond(fc), .pgf_cond(pc), .warn_cond(wc),
        .temp_cond(tc), .en_gate(en), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .fault_n(fault_n), .pwr_good(pwr_good),
        .warn_ind(warn_ind), .gate_hiz(gate_hiz), .clr_bit(clr_bit),
        .status_word(status_word));

    int checks = 0, fails = 0;
    bit done = 0;

    // Reference state built from the requirements.
    logic [NF-1:0] m_flt; logic [NP-1:0] m_pg; logic [NW-1:0] m_warn;
    logic [NT-1:0] m_temp; logic m_clr, m_enq;

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [SW-1:0] m_status();
        return {m_temp, m_warn, m_pg, m_flt, |m_warn, |m_flt};
    endfunction

    task automatic compare_all();
        chk("R1", fault_n, m_flt == 0, "fault_n");
        chk("R10", pwr_good, m_pg == 0, "pwr_good");
        chk("R6", gate_hiz, (m_flt != 0) || (m_pg != 0), "gate_hiz");
        chk("R7", warn_ind, (m_warn != 0) && m_flt == 0 && m_pg == 0, "warn_ind");
        chk("R4", clr_bit, m_clr, "clr_bit");
        chk("R2", status_word, m_status(), "status_word");
    endtask

    // Advance one clock with the inputs now applied, update the model, check.
    task automatic step();
        logic ce;
        ce = m_clr | (en & ~m_enq);
        m_flt  = fc | (ce ? '0 : m_flt);
        m_pg   = pc | (ce ? '0 : m_pg);
        m_warn = wc;
        m_temp = tc;
        m_clr  = wr_en && (wr_addr == AW'(CTRL)) && wr_data[1];
        m_enq  = en;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        fc = '0; pc = '0; wc = '0; tc = '0; en = 1'b1;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic write_clear(logic [AW-1:0] a, logic [DW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step();
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4177);
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        m_flt = '0; m_pg = '0; m_warn = '0; m_temp = '0; m_clr = 1'b0; m_enq = 1'b1;
        // R11 reset state
        chk("R11", {fault_n, pwr_good, gate_hiz, warn_ind, clr_bit}, 5'b11000, "pins after reset");
        chk("R11", status_word, 0, "status after reset");

        // R1 single fault, then R2 hold after it goes away
        fc = 6'b000100; step();
        chk("R1", status_word[0], 1, "fault summary");
        chk("R1", status_word[4], 1, "source 2 bit");
        fc = '0; repeat (3) step();
        chk("R2", fault_n, 0, "held after condition gone");

        // R7 warning during fault is suppressed; warning status still live (R8)
        wc = 4'b0010; step();
        chk("R7", warn_ind, 0, "warning under fault");
        chk("R8", status_word[1], 1, "warning summary live");

        // R3 clear while condition present has no effect
        fc = 6'b000100;
        write_clear(AW'(CTRL), 8'h02); step();
        chk("R3", fault_n, 0, "clear blocked by live condition");
        chk("R4", clr_bit, 0, "clear bit self-cleared");
        fc = '0; step();

        // R4 wrong address / wrong bit: no effect
        write_clear(4'd8, 8'h02); step();
        write_clear(AW'(CTRL), 8'hFD); step();
        chk("R4", fault_n, 0, "ignored writes kept fault");

        // R4 proper clear; R7 warning now visible
        write_clear(AW'(CTRL), 8'h02);
        chk("R4", clr_bit, 1, "clear bit set");
        step();
        chk("R4", clr_bit, 0, "clear bit dropped");
        chk("R3", fault_n, 1, "fault released");
        chk("R7", warn_ind, 1, "warning after clear");
        wc = '0; step();
        chk("R8", status_word[1], 0, "warning not latched");

        // R5 enable pulse: held low clears nothing, rise clears
        fc = 6'b100000; step(); fc = '0;
        en = 1'b0; repeat (5) step();
        chk("R5", fault_n, 0, "enable held low");
        en = 1'b1; step();
        chk("R5", fault_n, 1, "enable rise clears");
        repeat (4) step();

        // R9 temperature flags
        tc = 3'b101; step();
        chk("R9", status_word[SW-1 -: NT], 3'b101, "temp field");
        chk("R9", {fault_n, gate_hiz, warn_ind, pwr_good}, 4'b1001, "temp no effect");
        tc = '0; step();
        chk("R9", status_word[SW-1 -: NT], 0, "temp not latched");

        // R10 supply fault on power-good only
        pc = 2'b01; step(); pc = '0; step();
        chk("R10", {pwr_good, fault_n, status_word[0]}, 3'b010, "supply fault routing");
        chk("R6", gate_hiz, 1, "supply fault shuts gates");
        write_clear(AW'(CTRL), 8'h02); step();
        chk("R6", gate_hiz, 0, "all released");

        // Random traffic checked against the model
        for (int n = 0; n < 4000; n++) begin
            fc = NF'($urandom & $urandom & $urandom & $urandom);
            pc = NP'($urandom & $urandom & $urandom & $urandom);
            wc = NW'($urandom & $urandom);
            tc = NT'($urandom);
            en = ($urandom % 8) != 0;
            wr_en = ($urandom % 6) == 0;
            wr_addr = ($urandom % 2) ? AW'(CTRL) : AW'($urandom);
            wr_data = DW'($urandom);
            step();
        end
        idle(); step();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule